// File: doc/BRIEF.md
# Serial-to-Parallel Front End for a 64-Point Transform

This block sits at the input of a streaming 64-point FFT/IFFT core built from two stages of eight-point transforms. Each clock edge on which the qualifier is high, the block takes one complex sample, 32 bits wide with the real part in the upper half and the imaginary part in the lower half. A per-sample transform-select input exchanges the two halves before storage. The same exchange applied again at the output of the core turns the forward transform into an unscaled inverse transform.

Samples fill a 64-entry register array. Group l of the first transform stage is made of the frame samples l, l+8, ..., l+56. The last member of group l is frame sample 56+l, so group 0 is complete once 57 samples have been taken. From then on, each accepted sample completes one group, and that group is presented as one 256-bit word with a one-cycle valid pulse. A 5-bit pacing count of accepted samples is driven out so that later units can run in step with the input. Frames follow one another with no gap, because a slot is never rewritten before its group has left.

Top module: `fft_in_front`

## Requirements
- R1: After reset, with no sample taken, `grp_valid` is 0, `pace_cnt` is 0 and `grp_data` is all zeros.
- R2: A sample taken with `inv_mode` = 0 is stored unchanged.
- R3: A sample taken with `inv_mode` = 1 is stored with bits [31:16] and [15:0] exchanged. The mode is sampled with each sample, so the modes may be mixed inside one frame.
- R4: On a cycle with `in_valid` = 0, `in_sample` and `inv_mode` are ignored: no slot is written and the pacing count holds.
- R5: `pace_cnt` equals the number of samples accepted since reset, modulo 32.
- R6: The edge that accepts frame sample 56+l (l = 0..7) releases group l. `grp_valid` is 1 in the cycle after that edge and 0 in every other cycle, so the first release of a frame follows the 57th sample.
- R7: In a released group l, lane m (bits [32m+31:32m], m = 0..7) holds stored frame sample l+8m, and `grp_idx` equals l.
- R8: When releases fall on consecutive cycles, `grp_idx` rises by one from each release to the next.
- R9: The sample accepted after frame sample 63 is frame sample 0 of the next frame. Back-to-back frames are grouped correctly with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` on this edge |
| inv_mode | input | 1 | 0 forward, 1 inverse (halves exchanged) |
| in_sample | input | 32 | Complex sample, real in [31:16], imaginary in [15:0] |
| grp_valid | output | 1 | One-cycle pulse per released group |
| grp_idx | output | 3 | Index l of the released group |
| grp_data | output | 256 | Eight stored samples of group l, lane m at [32m+31:32m] |
| pace_cnt | output | 5 | Accepted-sample count modulo 32 |

## Verification
Checks that run on every cycle cover the pacing count: it steps on a qualified sample and holds otherwise. They also cover the array contents (a write lands in the addressed slot, and an unqualified cycle leaves all 64 slots untouched), the tie between each valid pulse and a release decision one edge earlier, and the step of the group index across adjacent releases. Other properties need a reference frame, and only the bench scenarios can show them. These are the stride pattern inside each 256-bit word, the half exchange under mixed per-sample modes, the exact cycle of the first release after 57 samples, and correct grouping across back-to-back frames and gaps.

// File: rtl/fft_in_pkg.sv
package fft_in_pkg;

    typedef enum logic {
        XFORM_FWD = 1'b0,
        XFORM_INV = 1'b1
    } xform_e;

endpackage

// File: rtl/fft_in_swap.sv
module fft_in_swap
    import fft_in_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] raw,
    input  logic                inv,
    output logic [2*HALF_W-1:0] stored
);

    always_comb begin
        if (xform_e'(inv) == XFORM_INV) begin
            stored = {raw[HALF_W-1:0], raw[2*HALF_W-1:HALF_W]};
        end else begin
            stored = raw;
        end
    end

endmodule

// File: rtl/fft_in_pacer.sv
module fft_in_pacer #(
    parameter int RADIX = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic [$clog2(RADIX*RADIX)-1:0]      wr_slot,
    output logic                                rel_now,
    output logic [$clog2(RADIX)-1:0]            rel_grp,
    output logic [$clog2(RADIX*RADIX)-2:0]      pace_cnt
);

    localparam int FRAME  = RADIX * RADIX;
    localparam int POS_W  = $clog2(FRAME);
    localparam int PACE_W = POS_W - 1;
    localparam int GRP_W  = $clog2(RADIX);
    localparam logic [POS_W-1:0] REL_START = POS_W'(FRAME - RADIX);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pace_st_t;

    pace_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.pos = st_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_slot  = st_q.pos;
    assign rel_now  = in_valid && (st_q.pos >= REL_START);
    assign rel_grp  = st_q.pos[GRP_W-1:0];
    assign pace_cnt = st_q.pos[PACE_W-1:0];

    a_r5_pace_step: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_q.pos == $past(st_q.pos) + POS_W'(1));

    a_r4_pace_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.pos));

endmodule

// File: rtl/fft_in_buffer.sv
module fft_in_buffer #(
    parameter int SAMPLE_W = 32,
    parameter int RADIX    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(RADIX*RADIX)-1:0]     wr_slot,
    input  logic [SAMPLE_W-1:0]                wr_data,
    input  logic                               rel_now,
    input  logic [$clog2(RADIX)-1:0]           rel_grp,
    output logic                               grp_valid,
    output logic [$clog2(RADIX)-1:0]           grp_idx,
    output logic [RADIX*SAMPLE_W-1:0]          grp_data
);

    localparam int FRAME = RADIX * RADIX;
    localparam int POS_W = $clog2(FRAME);
    localparam int GRP_W = $clog2(RADIX);

    typedef struct packed {
        logic [FRAME-1:0][SAMPLE_W-1:0] mem;
        logic [RADIX-1:0][SAMPLE_W-1:0] grp;
        logic                           vld;
        logic [GRP_W-1:0]               idx;
    } buf_st_t;

    buf_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (wr_en) begin
            st_d.mem[wr_slot] = wr_data;
        end
        if (rel_now) begin
            st_d.vld = 1'b1;
            st_d.idx = rel_grp;
            for (int m = 0; m < RADIX; m++) begin
                st_d.grp[m] = st_d.mem[POS_W'(m * RADIX) | POS_W'(rel_grp)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_valid = st_q.vld;
    assign grp_idx   = st_q.idx;
    assign grp_data  = st_q.grp;

    a_r6_pulse_from_release: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(rel_now));

    a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(st_q.vld)) |-> st_q.idx == $past(st_q.idx) + GRP_W'(1));

    a_r2_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.mem[$past(wr_slot)] == $past(wr_data));

    a_r4_array_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.mem));

endmodule

// File: rtl/fft_in_front.sv
module fft_in_front #(
    parameter int HALF_W = 16,
    parameter int RADIX  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 in_valid,
    input  logic                                 inv_mode,
    input  logic [2*HALF_W-1:0]                  in_sample,
    output logic                                 grp_valid,
    output logic [$clog2(RADIX)-1:0]             grp_idx,
    output logic [RADIX*2*HALF_W-1:0]            grp_data,
    output logic [$clog2(RADIX*RADIX)-2:0]       pace_cnt
);

    localparam int SAMPLE_W = 2 * HALF_W;
    localparam int POS_W    = $clog2(RADIX * RADIX);
    localparam int GRP_W    = $clog2(RADIX);

    logic [SAMPLE_W-1:0] stored;
    logic [POS_W-1:0]    wr_slot;
    logic                rel_now;
    logic [GRP_W-1:0]    rel_grp;

    fft_in_swap #(.HALF_W(HALF_W)) u_swap (
        .raw    (in_sample),
        .inv    (inv_mode),
        .stored (stored)
    );

    fft_in_pacer #(.RADIX(RADIX)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wr_slot  (wr_slot),
        .rel_now  (rel_now),
        .rel_grp  (rel_grp),
        .pace_cnt (pace_cnt)
    );

    fft_in_buffer #(.SAMPLE_W(SAMPLE_W), .RADIX(RADIX)) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_slot   (wr_slot),
        .wr_data   (stored),
        .rel_now   (rel_now),
        .rel_grp   (rel_grp),
        .grp_valid (grp_valid),
        .grp_idx   (grp_idx),
        .grp_data  (grp_data)
    );

endmodule

// File: tb/fft_in_front_tb.sv
`timescale 1ns/1ps
module fft_in_front_tb_top;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         in_valid = 1'b0;
    logic         inv_mode = 1'b0;
    logic [31:0]  in_sample = '0;
    logic         grp_valid;
    logic [2:0]   grp_idx;
    logic [255:0] grp_data;
    logic [4:0]   pace_cnt;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    logic [31:0]  mframe [64];
    int           mpos = 0;
    int           macc = 0;
    string        cur_tag = "R2";

    logic [255:0] q_data [$];
    int           q_idx  [$];
    string        q_tag  [$];

    always #(CLK_P/2) clk = ~clk;

    fft_in_front dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .inv_mode  (inv_mode),
        .in_sample (in_sample),
        .grp_valid (grp_valid),
        .grp_idx   (grp_idx),
        .grp_data  (grp_data),
        .pace_cnt  (pace_cnt)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic md, input logic [31:0] x);
        logic [31:0]  st;
        logic [255:0] g;
        @(negedge clk);
        in_valid  = v;
        inv_mode  = md;
        in_sample = x;
        if (v) begin
            st = md ? {x[15:0], x[31:16]} : x;
            mframe[mpos] = st;
            if (mpos >= 56) begin
                for (int m = 0; m < 8; m++) g[32*m +: 32] = mframe[(mpos - 56) + 8*m];
                q_data.push_back(g);
                q_idx.push_back(mpos - 56);
                q_tag.push_back(cur_tag);
            end
            mpos = (mpos + 1) % 64;
            macc++;
        end
    endtask

    // monitor: scoreboard compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (mon_on) begin
                chk(pace_cnt == 5'(macc % 32), "R5 pace_cnt", 256'(pace_cnt), 256'(macc % 32));
                if (q_data.size() > 0) begin
                    logic [255:0] ed;
                    int ei;
                    string et;
                    ed = q_data.pop_front();
                    ei = q_idx.pop_front();
                    et = q_tag.pop_front();
                    chk(grp_valid == 1'b1, {"R6 release valid ", et}, 256'(grp_valid), 256'(1));
                    chk(grp_idx == 3'(ei), {"R7 R8 group index ", et}, 256'(grp_idx), 256'(ei));
                    chk(grp_data == ed, {"R7 group lanes ", et}, grp_data, ed);
                end else begin
                    chk(grp_valid == 1'b0, "R6 no release", 256'(grp_valid), 256'(0));
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(grp_valid == 1'b0, "R1 grp_valid", 256'(grp_valid), 256'(0));
        chk(pace_cnt == 5'd0, "R1 pace_cnt", 256'(pace_cnt), 256'(0));
        chk(grp_data == '0, "R1 grp_data", grp_data, '0);
        mon_on = 1'b1;

        // frame 0: forward mode, back-to-back (R2, R6, R7)
        cur_tag = "R2";
        for (int i = 0; i < 64; i++) drive(1'b1, 1'b0, {16'(i * 313 + 7), 16'(16'hF000 - i * 91)});
        // frame 1: inverse mode, immediately following (R3, R9)
        cur_tag = "R3 R9";
        for (int i = 0; i < 64; i++) drive(1'b1, 1'b1, {16'(i * 577 + 3), 16'(16'h0A00 + i * 29)});
        // frame 2: mixed modes with unqualified garbage cycles (R3, R4)
        cur_tag = "R3 R4";
        for (int i = 0; i < 64; i++) begin
            drive(1'b1, 1'(i % 3 == 0), {16'(16'h8000 ^ (i * 41)), 16'(i * 1021)});
            if (i % 5 == 2) drive(1'b0, 1'(i % 2), 32'hDEAD_BEEF ^ 32'(i));
            if (i == 60) begin
                drive(1'b0, 1'b1, 32'hFFFF_0000);
                drive(1'b0, 1'b0, 32'h1234_5678);
            end
        end
        // frame 3: forward again, back-to-back, after idle (R9)
        cur_tag = "R9";
        drive(1'b0, 1'b0, 32'h0);
        for (int i = 0; i < 64; i++) drive(1'b1, 1'b0, {16'(i), 16'(~i)});
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 32'hCAFE_F00D);
        @(posedge clk);
        #(CLK_P/2);
        chk(q_data.size() == 0, "R6 all groups released", 256'(q_data.size()), 256'(0));
        chk(pace_cnt == 5'(macc % 32), "R4 R5 pace after idle", 256'(pace_cnt), 256'(macc % 32));
        mon_on = 1'b0;
        done   = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule